// File: doc/BRIEF.md
# Vector Floating-Point Exception Trap Collector

This block works next to a vector floating-point unit that handles one lane per cycle, lowest lane first. An instruction opens with a one-cycle start pulse that captures the current floating-point control word, an inexact-suppress bit and a single-element bit. Each lane then arrives as a strobe carrying its lane index and five IEEE exception flags. For every lane the block decides whether the flags trigger a vector-exception trap, using the trap-enable byte of the captured control word. It also ORs the flags into a running sticky accumulator.

When the instruction ends, the block emits a one-cycle done pulse. If a lane trapped, done comes with a trap-valid flag and an 8-bit interruption code, and the control word is left alone. Otherwise done comes with a write strobe and a new control word whose sticky byte includes the accumulated flags. A combinational halt output tells the sequencer, in the same cycle as the lane, that this lane is the last one. This happens after a trapping lane, or after the first lane in single-element mode.

Top module: `vfx_trap_collector`

## Requirements
- R1: After reset, done_o, trap_valid_o, fpc_we_o and halt_o are 0, and trap_code_o and fpc_o are all zeros.
- R2: Lane flags map onto a byte as follows: invalid at bit 7, divide-by-zero at bit 6, overflow at bit 5, underflow at bit 4, inexact at bit 3, and bits 2:0 zero. lane_flags_i is ordered [4]=invalid, [3]=divide-by-zero, [2]=overflow, [1]=underflow, [0]=inexact. A lane traps only when this byte ANDed with control bits 31:24 is nonzero. A flag whose enable bit is clear never traps.
- R3: When several enabled flags are set, the reason code is that of the highest-priority one. Priority, highest first: invalid=1, divide-by-zero=2, overflow=3, underflow=4, inexact=5.
- R4: trap_code_o equals lane_idx_i of the trapping lane in bits 7:4 and the reason code in bits 3:0.
- R5: With inexact suppression captured as 1, a lane whose only enabled flag is inexact does not trap. Its flags still reach the sticky byte.
- R6: An instruction that ends without a trap pulses fpc_we_o together with done_o. fpc_o then equals the captured control word with the OR of all lane flag bytes merged into bits 23:16.
- R7: An instruction that ends in a trap pulses trap_valid_o with done_o, leaves fpc_we_o at 0 and leaves fpc_o unchanged.
- R8: halt_o is high during an accepted lane exactly when that lane traps or single-element mode is on. done_o follows in the next cycle, and no further lane is accepted.
- R9: With single-element mode captured as 1, the instruction ends after the first accepted lane.
- R10: Without a trap or single-element mode, the instruction ends after NUM_LANES accepted lanes. done_o is high for exactly one cycle.
- R11: A lane strobe while no instruction is open, and a start pulse while one is open, have no effect.
- R12: A lane with all flags clear never traps and adds nothing to the sticky byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens an instruction and captures the control inputs |
| fpc_i | input | 32 | Floating-point control word in effect for the instruction |
| xsup_i | input | 1 | Inexact-suppress control |
| single_i | input | 1 | Single-element mode |
| lane_valid_i | input | 1 | Lane result strobe |
| lane_idx_i | input | 4 | Index of the lane, reported in the trap code |
| lane_flags_i | input | 5 | Lane exception flags (invalid, div-by-zero, overflow, underflow, inexact) |
| halt_o | output | 1 | Current lane is the final one (trap or single mode) |
| done_o | output | 1 | Instruction finished, one-cycle pulse |
| trap_valid_o | output | 1 | Instruction ended with a vector-exception trap |
| trap_code_o | output | 8 | Interruption code: lane index and reason |
| fpc_o | output | 32 | Updated control word |
| fpc_we_o | output | 1 | Write strobe for fpc_o |

## Verification
The assertions assume that the sequencer follows the handshake. Lane strobes come only after a start pulse, and no lane is sent in the cycle after halt_o. The flag and index inputs are known whenever lane_valid_i is high. The bench's random instructions follow the halt output and stop issuing lanes when it rises. The bench breaks the handshake only in a few directed cases: an idle-time lane strobe and a start during an open instruction. In those cases only the port-level behaviour is checked.

// File: rtl/vfx_pkg.sv
package vfx_pkg;

    localparam int FLAG_W     = 5;
    localparam int BYTE_W     = 8;
    localparam int CTRL_W     = 32;
    localparam int MASK_LSB   = 24;
    localparam int STICKY_LSB = 16;
    localparam int IDX_W      = 4;
    localparam int REASON_W   = 4;

    typedef struct packed {
        logic invalid;
        logic divzero;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_flags_t;

    typedef enum logic [REASON_W-1:0] {
        RSN_NONE      = 4'd0,
        RSN_INVALID   = 4'd1,
        RSN_DIVZERO   = 4'd2,
        RSN_OVERFLOW  = 4'd3,
        RSN_UNDERFLOW = 4'd4,
        RSN_INEXACT   = 4'd5
    } trap_reason_t;

    function automatic logic [BYTE_W-1:0] flags_to_byte(input exc_flags_t f);
        return {f, 3'b000};
    endfunction

    // Highest-priority enabled cause; inexact alone is dropped when suppressed.
    function automatic trap_reason_t pick_reason(input logic [BYTE_W-1:0] hit,
                                                 input logic xsup);
        trap_reason_t r;
        r = RSN_NONE;
        for (int k = 3; k >= 0; k--) begin
            if (hit[BYTE_W-1-k]) r = trap_reason_t'(k + 1);
        end
        if (r == RSN_NONE && hit[3] && !xsup) r = RSN_INEXACT;
        return r;
    endfunction

endpackage

// File: rtl/vfx_trap_encoder.sv
module vfx_trap_encoder
    import vfx_pkg::*;
(
    input  exc_flags_t             flags,
    input  logic [BYTE_W-1:0]      enable_mask,
    input  logic                   xsup,
    input  logic [IDX_W-1:0]       lane_idx,
    output logic [BYTE_W-1:0]      flag_byte,
    output logic                   trap,
    output logic [BYTE_W-1:0]      code
);
    trap_reason_t reason;
    logic [BYTE_W-1:0] hit;

    always_comb begin
        flag_byte = flags_to_byte(flags);
        hit       = flag_byte & enable_mask;
        reason    = pick_reason(hit, xsup);
        trap      = (reason != RSN_NONE);
        code      = trap ? {lane_idx, reason} : '0;
    end
endmodule

// File: rtl/vfx_flag_accum.sv
module vfx_flag_accum
    import vfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              add_en,
    input  logic [BYTE_W-1:0] add_byte,
    output logic [BYTE_W-1:0] acc_next
);
    logic [BYTE_W-1:0] acc_q;

    assign acc_next = acc_q | (add_en ? add_byte : '0);

    always_ff @(posedge clk) begin
        if (rst || clear) acc_q <= '0;
        else if (add_en)  acc_q <= acc_next;
    end
endmodule

// File: rtl/vfx_lane_seq.sv
module vfx_lane_seq #(
    parameter int NUM_LANES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic lane_valid,
    input  logic lane_trap,
    input  logic single,
    output logic busy,
    output logic open_now,
    output logic accept,
    output logic early,
    output logic finish
);
    localparam int CNT_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_LANES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign open_now = start && !busy;
    assign accept   = busy && lane_valid;
    assign last     = (cnt_q == LAST);
    assign early    = accept && (lane_trap || single);
    assign finish   = accept && (lane_trap || single || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (open_now) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (finish) begin
            busy  <= 1'b0;
        end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vfx_trap_collector.sv
module vfx_trap_collector
    import vfx_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CTRL_W-1:0] fpc_i,
    input  logic              xsup_i,
    input  logic              single_i,
    input  logic              lane_valid_i,
    input  logic [IDX_W-1:0]  lane_idx_i,
    input  logic [FLAG_W-1:0] lane_flags_i,
    output logic              halt_o,
    output logic              done_o,
    output logic              trap_valid_o,
    output logic [BYTE_W-1:0] trap_code_o,
    output logic [CTRL_W-1:0] fpc_o,
    output logic              fpc_we_o
);
    logic [CTRL_W-1:0] fpc_cap;
    logic              xsup_cap, single_cap;
    logic              busy, open_now, accept, early, finish;
    logic              lane_trap;
    logic [BYTE_W-1:0] lane_byte, lane_code, acc_next;
    logic [CTRL_W-1:0] merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            fpc_cap    <= '0;
            xsup_cap   <= 1'b0;
            single_cap <= 1'b0;
        end else if (open_now) begin
            fpc_cap    <= fpc_i;
            xsup_cap   <= xsup_i;
            single_cap <= single_i;
        end
    end

    vfx_trap_encoder u_enc (
        .flags       (exc_flags_t'(lane_flags_i)),
        .enable_mask (fpc_cap[MASK_LSB +: BYTE_W]),
        .xsup        (xsup_cap),
        .lane_idx    (lane_idx_i),
        .flag_byte   (lane_byte),
        .trap        (lane_trap),
        .code        (lane_code)
    );

    vfx_lane_seq #(.NUM_LANES(NUM_LANES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .lane_valid (lane_valid_i),
        .lane_trap  (lane_trap),
        .single     (single_cap),
        .busy       (busy),
        .open_now   (open_now),
        .accept     (accept),
        .early      (early),
        .finish     (finish)
    );

    vfx_flag_accum u_acc (
        .clk      (clk),
        .rst      (rst),
        .clear    (open_now),
        .add_en   (accept),
        .add_byte (lane_byte),
        .acc_next (acc_next)
    );

    assign halt_o = early;

    always_comb begin
        merged = fpc_cap;
        merged[STICKY_LSB +: BYTE_W] = fpc_cap[STICKY_LSB +: BYTE_W] | acc_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o       <= 1'b0;
            trap_valid_o <= 1'b0;
            trap_code_o  <= '0;
            fpc_o        <= '0;
            fpc_we_o     <= 1'b0;
        end else begin
            done_o       <= finish;
            trap_valid_o <= finish && lane_trap;
            trap_code_o  <= (finish && lane_trap) ? lane_code : '0;
            fpc_we_o     <= finish && !lane_trap;
            if (finish && !lane_trap) fpc_o <= merged;
        end
    end

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_halt_then_done: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> (done_o && !busy));

    a_r7_trap_no_write: assert property (@(posedge clk) disable iff (rst)
        trap_valid_o |-> (!fpc_we_o && done_o && $stable(fpc_o)));

    a_r6_write_with_done: assert property (@(posedge clk) disable iff (rst)
        fpc_we_o |-> done_o);

    a_r4_code_reason: assert property (@(posedge clk) disable iff (rst)
        trap_valid_o |-> (trap_code_o[3:0] >= 4'd1 && trap_code_o[3:0] <= 4'd5));

    a_r11_idle_lane: assert property (@(posedge clk) disable iff (rst)
        (!busy && lane_valid_i) |=> !done_o);

    a_r12_zero_flags: assert property (@(posedge clk) disable iff (rst)
        (accept && lane_flags_i == '0) |=> !trap_valid_o);

    a_r5_inexact_suppressed: assert property (@(posedge clk) disable iff (rst)
        (accept && xsup_cap &&
         ((lane_byte & fpc_cap[MASK_LSB +: BYTE_W]) == 8'h08)) |=> !trap_valid_o);
endmodule

// File: tb/vfx_trap_collector_test.sv
module vfx_trap_collector_test;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] fpc_i = '0;
    logic        xsup_i = 1'b0;
    logic        single_i = 1'b0;
    logic        lane_valid_i = 1'b0;
    logic [3:0]  lane_idx_i = '0;
    logic [4:0]  lane_flags_i = '0;
    logic        halt_o, done_o, trap_valid_o, fpc_we_o;
    logic [7:0]  trap_code_o;
    logic [31:0] fpc_o;

    int tests = 0;
    int fails = 0;
    logic [31:0] exp_fpc = '0;

    always #5 clk = ~clk;

    vfx_trap_collector #(.NUM_LANES(NL)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .fpc_i(fpc_i),
        .xsup_i(xsup_i), .single_i(single_i), .lane_valid_i(lane_valid_i),
        .lane_idx_i(lane_idx_i), .lane_flags_i(lane_flags_i),
        .halt_o(halt_o), .done_o(done_o), .trap_valid_o(trap_valid_o),
        .trap_code_o(trap_code_o), .fpc_o(fpc_o), .fpc_we_o(fpc_we_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_reason(input logic [7:0] hit, input bit xs);
        if (hit[7]) return 4'd1;
        if (hit[6]) return 4'd2;
        if (hit[5]) return 4'd3;
        if (hit[4]) return 4'd4;
        if (hit[3] && !xs) return 4'd5;
        return 4'd0;
    endfunction

    task automatic open_instr(input logic [31:0] fpc, input bit xs, input bit sg);
        @(negedge clk);
        start_i = 1'b1; fpc_i = fpc; xsup_i = xs; single_i = sg;
        @(negedge clk);
        start_i = 1'b0; fpc_i = $urandom; xsup_i = $urandom; single_i = $urandom;
    endtask

    // Runs a full instruction; flags for lane k are fl[5*k +: 5].
    task automatic run_instr(input logic [31:0] fpc, input bit xs, input bit sg,
                             input logic [19:0] fl, input string tag);
        logic [7:0] acc, b, hit;
        logic [3:0] rsn;
        bit         trapped;
        logic [7:0] code;
        logic [31:0] want;
        acc = '0; trapped = 0; code = '0;
        open_instr(fpc, xs, sg);
        for (int k = 0; k < NL; k++) begin
            b   = {fl[5*k +: 5], 3'b000};
            hit = b & fpc[31:24];
            rsn = ref_reason(hit, xs);
            acc = acc | b;
            lane_valid_i = 1'b1; lane_idx_i = 4'(k); lane_flags_i = fl[5*k +: 5];
            #2;
            chk(halt_o == ((rsn != 0) || sg), "R8", {tag, " halt"},
                32'(halt_o), 32'((rsn != 0) || sg));
            @(negedge clk);
            if (rsn != 0) begin trapped = 1; code = {4'(k), rsn}; end
            if (trapped || sg) break;
        end
        lane_valid_i = 1'b0; lane_flags_i = '0;
        want = fpc;
        want[23:16] = fpc[23:16] | acc;
        chk(done_o == 1'b1, sg ? "R9" : "R10", {tag, " done"}, 32'(done_o), 1);
        chk(trap_valid_o == trapped, "R2", {tag, " trap_valid"},
            32'(trap_valid_o), 32'(trapped));
        chk(trap_code_o == code, "R4", {tag, " code"}, 32'(trap_code_o), 32'(code));
        chk(fpc_we_o == !trapped, trapped ? "R7" : "R6", {tag, " we"},
            32'(fpc_we_o), 32'(!trapped));
        if (!trapped) exp_fpc = want;
        chk(fpc_o == exp_fpc, trapped ? "R7" : "R6", {tag, " fpc"}, fpc_o, exp_fpc);
        @(negedge clk);
        chk(done_o == 1'b0, "R10", {tag, " done one cycle"}, 32'(done_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done_o && !trap_valid_o && !fpc_we_o && !halt_o, "R1", "flags",
            {done_o, trap_valid_o, fpc_we_o, halt_o}, 0);
        chk(trap_code_o == 0 && fpc_o == 0, "R1", "data", fpc_o, 0);

        // R3 priority cases, R4 lane in upper nibble
        run_instr(32'hFF00_0000, 0, 0, {5'd0, 5'd0, 5'd0, 5'b11111}, "R3 all");
        run_instr(32'hFF00_0000, 0, 0, {5'd0, 5'd0, 5'b01111, 5'd0}, "R3 dz");
        run_instr(32'hFF00_0000, 0, 0, {5'd0, 5'b00110, 5'd0, 5'd0}, "R4 ovf lane2");
        run_instr(32'h1000_0000, 0, 0, {5'b00010, 5'd0, 5'd0, 5'd0}, "R3 unf lane3");
        // R2: disabled flag does not trap, goes sticky
        run_instr(32'h4000_0000, 0, 0, {5'd0, 5'd0, 5'b10000, 5'd0}, "R2 masked");
        // R5 inexact suppression on and off
        run_instr(32'h0800_0000, 1, 0, {5'd0, 5'd1, 5'd0, 5'd0}, "R5 sup");
        run_instr(32'h0800_0000, 0, 0, {5'd0, 5'd1, 5'd0, 5'd0}, "R5 nosup");
        // R9 single-element
        run_instr(32'h0000_0000, 0, 1, {5'd31, 5'd31, 5'd31, 5'b00100}, "R9 single");
        // R12 zero flags
        run_instr(32'hFF12_3456, 0, 0, 20'd0, "R12 zero");
        chk(fpc_o == 32'hFF12_3456, "R12", "sticky untouched", fpc_o, 32'hFF12_3456);

        // R11: idle lane strobe ignored
        @(negedge clk);
        lane_valid_i = 1'b1; lane_flags_i = 5'b11111; lane_idx_i = 4'd7;
        @(negedge clk);
        lane_valid_i = 1'b0; lane_flags_i = '0;
        chk(done_o == 0 && trap_valid_o == 0, "R11", "idle lane",
            {done_o, trap_valid_o}, 0);
        // R11: start during open instruction ignored
        open_instr(32'h0000_0000, 0, 0);
        for (int k = 0; k < NL; k++) begin
            lane_valid_i = 1'b1; lane_idx_i = 4'(k);
            lane_flags_i = (k == 1) ? 5'b00001 : 5'd0;
            start_i = (k == 1); fpc_i = 32'hFFFF_FFFF; single_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        lane_valid_i = 1'b0; lane_flags_i = '0;
        chk(done_o && !trap_valid_o && fpc_we_o, "R11", "restart ignored",
            {done_o, trap_valid_o, fpc_we_o}, 3'b101);
        exp_fpc = 32'h0008_0000;
        chk(fpc_o == exp_fpc, "R11", "restart fpc", fpc_o, exp_fpc);
        @(negedge clk);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [31:0] f;
            logic [19:0] fl;
            f = $urandom;
            if (($urandom % 4) == 0) f[31:24] = 8'h00;
            fl = $urandom;
            for (int k = 0; k < NL; k++) if (($urandom % 3) == 0) fl[5*k +: 5] = '0;
            run_instr(f, 1'($urandom), (($urandom % 5) == 0), fl, "R2 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule